// File: doc/BRIEF.md
# Longword-to-Word Register Access Splitter

This bridge sits between a 32-bit processor-side request port and a 16-bit peripheral register space in which every bus cycle lasts a fixed number of clocks (three by default). A word request becomes one peripheral bus cycle. A longword request becomes two word cycles that run back to back. While the pair runs, a lock output stays high so that the bus arbiter cannot hand the bus to another master between the halves. The upper half goes first, at the longword-aligned address. The lower half follows at that address plus two.

For a read, the bridge latches the first word and joins it with the second into a 32-bit result. It then raises a single-clock ready to the processor side. A write works the same way: the bridge takes the 32-bit write data in one request and steers each half onto the 16-bit write bus in turn. The bridge takes a request only while idle. Any request made while a transfer is in flight, or in its ready clock, is dropped.

Top module: `lw_word_bridge`

## Requirements
- R1: While reset is high and in the first clock after it, per_sel, per_lock and cpu_ready are all 0.
- R2: A word request (cpu_long=0) that is accepted at a clock edge runs exactly one peripheral cycle. per_sel stays high for CYC consecutive clocks at address cpu_addr with bit 0 cleared. cpu_ready rises CYC+1 clocks after the accepting edge.
- R3: A longword request (cpu_long=1) runs two contiguous peripheral cycles with no idle clock between them, 2*CYC clocks of per_sel in all. The first cycle uses cpu_addr with bits 1:0 cleared and the second uses that address plus 2. cpu_ready rises 2*CYC+1 clocks after the accepting edge.
- R4: per_lock is high in every clock of both cycles of a longword access. It is low during every cycle of a word access.
- R5: For a write (cpu_we=1), per_we is high in every clock of the cycles. A word write drives cpu_wdata[15:0]. A longword write drives cpu_wdata[31:16] in the first cycle and cpu_wdata[15:0] in the second. per_addr, per_we and per_wdata stay stable within each cycle.
- R6: A word read returns {16'h0000, data} on cpu_rdata. A longword read returns {first-cycle data, second-cycle data}. In each case per_rdata is sampled in the last clock of its cycle, and the result is valid while cpu_ready is high.
- R7: cpu_ready is a one-clock pulse, and per_sel is low while it is high.
- R8: A request presented while a transfer is in flight or during its ready clock is ignored. It starts no extra peripheral cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, taken only while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_long | input | 1 | 1 = longword, 0 = word |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 2*DW | Write data |
| cpu_rdata | output | 2*DW | Assembled read data |
| cpu_ready | output | 1 | One-clock completion pulse |
| per_sel | output | 1 | Peripheral bus cycle active |
| per_we | output | 1 | Peripheral write strobe |
| per_lock | output | 1 | Bus lock across a longword pair |
| per_addr | output | AW | Peripheral word address |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data |

## Verification
Suppose the phase counter or the sequencer state is corrupted. The first sign is the length of the per_sel window, which comes out shorter or longer than CYC or 2*CYC, or shows a gap between the halves. The ready latency shifts in the same transfer. If the half-select or the captured request is wrong, the fault shows within that transfer as a swapped or repeated address, misplaced write halves, or swapped halves in cpu_rdata. A lock fault shows as per_lock dropping inside the pair, or rising on a word access.

// File: rtl/lw_word_bridge_pkg.sv
package lw_word_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lw_word_seq.sv
module lw_word_seq
  import lw_word_bridge_pkg::*;
#(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic long_in,
  output logic load,
  output logic sel,
  output logic lock,
  output logic ready,
  output logic in_second,
  output logic ph_zero,
  output logic smp_first,
  output logic smp_second
);
  localparam int PHW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [PHW-1:0] PH_LAST = PHW'(CYC - 1);

  seq_state_e st_q;
  logic [PHW-1:0] ph_q;
  logic long_q;
  logic ph_last;

  assign ph_last    = (ph_q == PH_LAST);
  assign load       = (st_q == ST_IDLE) && req;
  assign sel        = (st_q == ST_HI) || (st_q == ST_LO);
  assign lock       = sel && long_q;
  assign ready      = (st_q == ST_DONE);
  assign in_second  = (st_q == ST_LO);
  assign ph_zero    = (ph_q == '0);
  assign smp_first  = (st_q == ST_HI) && ph_last;
  assign smp_second = (st_q == ST_LO) && ph_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      long_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req) begin
            st_q   <= ST_HI;
            ph_q   <= '0;
            long_q <= long_in;
          end
        end
        ST_HI: begin
          if (ph_last) begin
            ph_q <= '0;
            st_q <= long_q ? ST_LO : ST_DONE;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_LO: begin
          if (ph_last) begin
            ph_q <= '0;
            st_q <= ST_DONE;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          long_q <= 1'b0;
        end
      endcase
    end
  end

  // R3
  sel_end_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sel) |-> ready);

  // R2
  hi_cycle_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel) |-> ph_zero);
endmodule

// File: rtl/lw_word_path.sv
module lw_word_path #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            sel,
  input  logic            in_second,
  input  logic            smp_first,
  input  logic            smp_second,
  input  logic            cpu_we,
  input  logic            cpu_long,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [2*DW-1:0] cpu_wdata,
  input  logic [DW-1:0]   per_rdata,
  output logic [AW-1:0]   per_addr,
  output logic [DW-1:0]   per_wdata,
  output logic            per_we,
  output logic [2*DW-1:0] cpu_rdata
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] LONG_MASK = ~AW'(3);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(1);
  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  logic [AW-1:0] base_q;
  logic          we_q;
  logic          long_q;
  logic [CW-1:0] wd_q;
  logic [DW-1:0] hi_q;
  logic [CW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      we_q   <= 1'b0;
      long_q <= 1'b0;
      wd_q   <= '0;
    end else if (load) begin
      base_q <= cpu_addr & (cpu_long ? LONG_MASK : WORD_MASK);
      we_q   <= cpu_we;
      long_q <= cpu_long;
      wd_q   <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      rd_q <= '0;
    end else begin
      if (smp_first) begin
        if (long_q) hi_q <= per_rdata;
        else        rd_q <= {{DW{1'b0}}, per_rdata};
      end
      if (smp_second) rd_q <= {hi_q, per_rdata};
    end
  end

  assign per_addr  = in_second ? (base_q | HALF_STEP) : base_q;
  assign per_wdata = (long_q && !in_second) ? wd_q[CW-1:DW] : wd_q[DW-1:0];
  assign per_we    = we_q && sel;
  assign cpu_rdata = rd_q;

  // R3
  lo_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_second) |-> (per_addr == $past(per_addr) + HALF_STEP));
endmodule

// File: rtl/lw_word_bridge.sv
module lw_word_bridge #(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int CYC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic            cpu_long,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [2*DW-1:0] cpu_wdata,
  output logic [2*DW-1:0] cpu_rdata,
  output logic            cpu_ready,
  output logic            per_sel,
  output logic            per_we,
  output logic            per_lock,
  output logic [AW-1:0]   per_addr,
  output logic [DW-1:0]   per_wdata,
  input  logic [DW-1:0]   per_rdata
);
  logic load, in_second, ph_zero, smp_first, smp_second;

  lw_word_seq #(.CYC(CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req        (cpu_req),
    .long_in    (cpu_long),
    .load       (load),
    .sel        (per_sel),
    .lock       (per_lock),
    .ready      (cpu_ready),
    .in_second  (in_second),
    .ph_zero    (ph_zero),
    .smp_first  (smp_first),
    .smp_second (smp_second)
  );

  lw_word_path #(.AW(AW), .DW(DW)) u_path (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .sel        (per_sel),
    .in_second  (in_second),
    .smp_first  (smp_first),
    .smp_second (smp_second),
    .cpu_we     (cpu_we),
    .cpu_long   (cpu_long),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .per_rdata  (per_rdata),
    .per_addr   (per_addr),
    .per_wdata  (per_wdata),
    .per_we     (per_we),
    .cpu_rdata  (cpu_rdata)
  );

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R7
  ready_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !per_sel);

  // R4
  lock_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    per_lock |-> per_sel);

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (per_sel && !ph_zero) |-> $stable(per_addr));

  // R5
  wr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (per_sel && !ph_zero) |-> ($stable(per_we) && $stable(per_wdata)));
endmodule

// File: tb/lw_word_bridge_tb.sv
`timescale 1ns/1ps
module lw_word_bridge_tb;
  localparam int AW  = 12;
  localparam int DW  = 16;
  localparam int CYC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_long = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [2*DW-1:0] cpu_wdata = '0;
  logic [2*DW-1:0] cpu_rdata;
  logic cpu_ready, per_sel, per_we, per_lock;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata, per_rdata;

  always #2.5 clk = ~clk;

  lw_word_bridge #(.AW(AW), .DW(DW), .CYC(CYC)) u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_long(cpu_long), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .per_sel(per_sel),
    .per_we(per_we), .per_lock(per_lock), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  // Peripheral model: 64 words, write lands in the last clock of a cycle
  logic [DW-1:0] mem [64];
  int pcnt;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 16'hA000 ^ 16'(i * 16'h0137);
      pcnt <= 0;
    end else if (per_sel) begin
      if (pcnt == CYC - 1) begin
        if (per_we) mem[per_addr[6:1]] <= per_wdata;
        pcnt <= 0;
      end else pcnt <= pcnt + 1;
    end else pcnt <= 0;
  end
  assign per_rdata = per_sel ? mem[per_addr[6:1]] : 16'hDEAD;

  // Bus monitor
  int n_log;
  logic [AW-1:0] lg_addr [16];
  logic          lg_we [16], lg_lock [16];
  logic [DW-1:0] lg_wd [16];
  always @(negedge clk) begin
    if (per_sel && n_log < 16) begin
      lg_addr[n_log] <= per_addr;
      lg_we[n_log]   <= per_we;
      lg_lock[n_log] <= per_lock;
      lg_wd[n_log]   <= per_wdata;
      n_log <= n_log + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_base(input logic [AW-1:0] a, input bit lng);
    return lng ? (a & ~AW'(3)) : (a & ~AW'(1));
  endfunction

  task automatic xfer(input bit we, input bit lng, input logic [AW-1:0] a,
                      input logic [31:0] wd, input bit poke);
    logic [AW-1:0] b;
    logic [31:0] exp_rd;
    int cnt, ncyc;
    b = exp_base(a, lng);
    exp_rd = lng ? {mem[b[6:1]], mem[b[6:1] + 6'd1]} : {16'h0, mem[b[6:1]]};
    ncyc = lng ? 2 * CYC : CYC;
    @(negedge clk);
    n_log = 0;
    cpu_req = 1; cpu_we = we; cpu_long = lng; cpu_addr = a; cpu_wdata = wd;
    cnt = 0;
    while (cnt < 40) begin
      @(negedge clk);
      cnt++;
      cpu_req = (poke && cnt == 2);
      if (poke && cnt == 2) begin cpu_addr = a ^ AW'(8); cpu_long = ~lng; end
      if (cpu_ready) break;
    end
    // R2 R3 latency
    check(cnt == ncyc + 1, lng ? "R3 latency" : "R2 latency", cnt, ncyc + 1);
    if (!we) check(cpu_rdata == exp_rd, "R6 read data", cpu_rdata, exp_rd);
    if (poke) cpu_req = 1;       // R8 request in the ready clock
    @(negedge clk);
    cpu_req = 0;
    check(per_sel == 0, "R8 ignored request", per_sel, 0);
    check(n_log == ncyc, "R3 cycle clocks", n_log, ncyc);
    for (int i = 0; i < ncyc && i < 16; i++) begin
      logic [AW-1:0] ea;
      logic [DW-1:0] ew;
      ea = (i >= CYC) ? (b | AW'(2)) : b;
      ew = (lng && i < CYC) ? wd[31:16] : wd[15:0];
      check(lg_addr[i] == ea, lng ? "R3 address" : "R2 address", lg_addr[i], ea);
      check(lg_lock[i] == lng, "R4 lock", lg_lock[i], lng);
      check(lg_we[i] == we, "R5 write strobe", lg_we[i], we);
      if (we) check(lg_wd[i] == ew, "R5 write data", lg_wd[i], ew);
    end
    if (we) begin
      check(mem[b[6:1]] == (lng ? wd[31:16] : wd[15:0]), "R5 stored word",
            mem[b[6:1]], lng ? wd[31:16] : wd[15:0]);
      if (lng) check(mem[b[6:1] + 6'd1] == wd[15:0], "R5 stored low", mem[b[6:1] + 6'd1], wd[15:0]);
    end
    repeat (2) begin
      @(negedge clk);
      check(per_sel == 0 && cpu_ready == 0, "R8 stays idle", per_sel, 0);
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    n_log = 0;
    repeat (3) @(negedge clk);
    check(per_sel == 0 && per_lock == 0 && cpu_ready == 0, "R1 in reset", {per_sel, per_lock, cpu_ready}, 0);
    rst = 0;
    @(negedge clk);
    check(per_sel == 0 && per_lock == 0 && cpu_ready == 0, "R1 after reset", {per_sel, per_lock, cpu_ready}, 0);
    // directed corner cases
    xfer(0, 0, 12'h011, 32'h0, 0);          // R2 word read, odd byte address
    xfer(0, 1, 12'h013, 32'h0, 0);          // R3 long read, unaligned address
    xfer(1, 1, 12'h020, 32'h1234_5678, 0);  // R5 long write
    xfer(0, 1, 12'h020, 32'h0, 0);          // R6 read back both halves
    xfer(1, 0, 12'h07E, 32'hFFFF_BEEF, 0);  // R5 word write at top word
    xfer(1, 1, 12'h040, 32'hCAFE_F00D, 1);  // R8 requests while busy
    xfer(0, 0, 12'h048, 32'h0, 1);          // R8 on a word transfer
    for (int k = 0; k < 150; k++) begin
      xfer(1'($urandom), 1'($urandom), AW'($urandom & 32'h7F), $urandom, 1'($urandom));
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule